// File: doc/BRIEF.md
# Serial Threshold Register Bank for a Multichannel Discriminator

This block stores one discriminator threshold per channel of a sixteen-channel front-end chip. Each threshold is a 7-bit code: four bits set the fine level and three more bits widen the range to absorb gain spread between channels. Each code drives the DAC input of its channel at all times. A control unit fetches the calibration values from its own memory and writes them one channel at a time over a four-wire serial port. This keeps the chip's pin count low. The same port returns any stored code so that the controller can confirm the settings.

A frame opens when the frame strobe goes low. While the strobe is low, bits are taken on rising edges of the serial clock, most significant bit first. The first bit selects the direction (1 = write, 0 = read). The next four bits give the channel number, most significant first. The last seven bits carry the code, most significant first. A write takes effect when the strobe goes high again, and only if exactly twelve bits were taken in that frame. All serial inputs pass through two-flop synchronisers into the system clock domain, and their edges are detected in that domain. The serial clock must therefore run several times slower than the system clock.

Top module: `thresh_bank`

## Requirements
- R1: After reset every channel holds the code 64 and the data-out line is low.
- R2: A write frame of exactly 12 bits replaces only the addressed channel's code, and that code is held until the channel is written again.
- R3: Field order within a frame is direction bit (1 = write, 0 = read), then channel number bits 3..0, then code bits 6..0, with each bit taken on a rising serial-clock edge while the strobe is low.
- R4: A frame of fewer than 12 bits changes no channel.
- R5: A frame of more than 12 bits changes no channel.
- R6: In a read frame, code bit 6..0 of the addressed channel is placed on data-out after the 5th rising edge and advances one bit after each of the following rising edges, so that it can be sampled before edges 6 to 12.
- R7: A read frame changes no channel, whatever its code field carries.
- R8: Serial-clock edges while the strobe is high have no effect, and data-out is low whenever the strobe has been high for three system clocks.
- R9: At most one channel changes in any one system clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| serClk | input | 1 | Serial clock; bits are taken on its rising edges |
| serDin | input | 1 | Serial data from the controller |
| serStrobeN | input | 1 | Frame strobe; a frame lasts while it is low |
| serDout | output | 1 | Serial readback data |
| thrCodes | output | 112 | Channel codes, channel n at bits [7n+6:7n] |

## Verification
The bench sends frames that are one bit short and one bit long. A design that committed on strobe rise without checking the exact bit count would corrupt a channel on these frames. It reads back channels 0, 15 and a written middle channel, and uses addresses such as 8 against 1. A reversed address order or a misaligned readback shift would therefore show as wrong data or a swapped channel. It sends a read frame with an all-ones code field, to catch a design that writes regardless of the direction bit. It also toggles the serial clock with the strobe high, to catch a bit counter that keeps running outside a frame and breaks the frame that follows.

// File: rtl/thresh_pkg.sv
package thresh_pkg;
  typedef struct packed {
    logic shiftEn;
    logic readLoad;
    logic readShift;
    logic commit;
    logic clearFrame;
  } ctrlStrobes_t;
endpackage

// File: rtl/thresh_sync.sv
module thresh_sync #(
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut,
  output logic syncPrev
);
  logic [1:0] stages;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stages   <= {2{RESET_VAL}};
      syncPrev <= RESET_VAL;
    end else begin
      stages   <= {stages[0], asyncIn};
      syncPrev <= stages[1];
    end
  end
  assign syncOut = stages[1];
endmodule

// File: rtl/thresh_ctrl.sv
module thresh_ctrl
  import thresh_pkg::*;
#(
  parameter int FRAME_BITS = 12,
  parameter int HDR_BITS   = 5
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         serClk,
  input  logic         serDin,
  input  logic         serStrobeN,
  output logic         dinSync,
  output ctrlStrobes_t strobes
);
  localparam int CNT_W = $clog2(FRAME_BITS + 2);

  logic sClk, clkPrev, sStrb, strbPrev, dinPrev;
  logic [CNT_W-1:0] bitCnt;
  logic clkRise, strbRise, strbFall, frameOn;

  thresh_sync #(.RESET_VAL(1'b0)) u_clkSync (
    .clk(clk), .rstN(rstN), .asyncIn(serClk), .syncOut(sClk), .syncPrev(clkPrev));
  thresh_sync #(.RESET_VAL(1'b1)) u_strbSync (
    .clk(clk), .rstN(rstN), .asyncIn(serStrobeN), .syncOut(sStrb), .syncPrev(strbPrev));
  thresh_sync #(.RESET_VAL(1'b0)) u_dinSync (
    .clk(clk), .rstN(rstN), .asyncIn(serDin), .syncOut(dinSync), .syncPrev(dinPrev));

  assign clkRise  = sClk & ~clkPrev;
  assign strbRise = sStrb & ~strbPrev;
  assign strbFall = ~sStrb & strbPrev;
  assign frameOn  = ~sStrb;

  always_comb begin
    strobes.shiftEn    = clkRise & frameOn & (bitCnt < CNT_W'(FRAME_BITS));
    strobes.readLoad   = strobes.shiftEn & (bitCnt == CNT_W'(HDR_BITS - 1));
    strobes.readShift  = strobes.shiftEn & (bitCnt >= CNT_W'(HDR_BITS));
    strobes.commit     = strbRise & (bitCnt == CNT_W'(FRAME_BITS));
    strobes.clearFrame = strbRise | strbFall;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      bitCnt <= '0;
    else if (strbFall)
      bitCnt <= '0;
    else if (clkRise && frameOn && bitCnt <= CNT_W'(FRAME_BITS))
      bitCnt <= bitCnt + 1'b1;
  end
endmodule

// File: rtl/thresh_regs.sv
module thresh_regs
  import thresh_pkg::*;
#(
  parameter int          NUM_CH     = 16,
  parameter int          CODE_W     = 7,
  parameter int          ADDR_W     = 4,
  parameter int          RESET_CODE = 64
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     dinSync,
  input  ctrlStrobes_t             strobes,
  output logic                     serDout,
  output logic [NUM_CH*CODE_W-1:0] thrCodes
);
  localparam int FRAME_W = 1 + ADDR_W + CODE_W;

  logic [FRAME_W-1:0] frameSr, srNext;
  logic [CODE_W-1:0]  bank [NUM_CH];
  logic [CODE_W-1:0]  readReg, readSel;
  logic [ADDR_W-1:0]  hdrAddr, wrAddr;
  logic               hdrRead, wrDir;

  assign srNext  = {frameSr[FRAME_W-2:0], dinSync};
  assign hdrAddr = srNext[ADDR_W-1:0];
  assign hdrRead = ~srNext[ADDR_W];
  assign wrDir   = frameSr[FRAME_W-1];
  assign wrAddr  = frameSr[FRAME_W-2 -: ADDR_W];
  assign readSel = (32'(hdrAddr) < NUM_CH) ? bank[hdrAddr] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      frameSr <= '0;
    else if (strobes.shiftEn)
      frameSr <= srNext;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        bank[ch] <= CODE_W'(RESET_CODE);
      else if (strobes.commit && wrDir && wrAddr == ADDR_W'(ch))
        bank[ch] <= frameSr[CODE_W-1:0];
    end
    assign thrCodes[ch*CODE_W +: CODE_W] = bank[ch];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      readReg <= '0;
    else if (strobes.clearFrame)
      readReg <= '0;
    else if (strobes.readLoad)
      readReg <= hdrRead ? readSel : '0;
    else if (strobes.readShift)
      readReg <= {readReg[CODE_W-2:0], 1'b0};
  end

  assign serDout = readReg[CODE_W-1];
endmodule

// File: rtl/thresh_bank.sv
module thresh_bank
  import thresh_pkg::*;
#(
  parameter int NUM_CH     = 16,
  parameter int CODE_W     = 7,
  parameter int RESET_CODE = 64
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     serClk,
  input  logic                     serDin,
  input  logic                     serStrobeN,
  output logic                     serDout,
  output logic [NUM_CH*CODE_W-1:0] thrCodes
);
  localparam int ADDR_W     = $clog2(NUM_CH);
  localparam int HDR_BITS   = 1 + ADDR_W;
  localparam int FRAME_BITS = HDR_BITS + CODE_W;

  ctrlStrobes_t strobes;
  logic         dinSync;

  thresh_ctrl #(.FRAME_BITS(FRAME_BITS), .HDR_BITS(HDR_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serDin(serDin),
    .serStrobeN(serStrobeN), .dinSync(dinSync), .strobes(strobes));

  thresh_regs #(.NUM_CH(NUM_CH), .CODE_W(CODE_W), .ADDR_W(ADDR_W),
                .RESET_CODE(RESET_CODE)) u_regs (
    .clk(clk), .rstN(rstN), .dinSync(dinSync), .strobes(strobes),
    .serDout(serDout), .thrCodes(thrCodes));
endmodule

// File: rtl/thresh_bank_chk.sv
module thresh_bank_chk #(
  parameter int NUM_CH     = 16,
  parameter int CODE_W     = 7,
  parameter int RESET_CODE = 64
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     serStrobeN,
  input logic                     serDout,
  input logic [NUM_CH*CODE_W-1:0] thrCodes
);
  logic [NUM_CH*CODE_W-1:0] prevCodes;
  logic [NUM_CH-1:0]        chanMoved;

  always_ff @(posedge clk) prevCodes <= thrCodes;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_mv
    assign chanMoved[ch] = thrCodes[ch*CODE_W +: CODE_W] != prevCodes[ch*CODE_W +: CODE_W];
  end

  // R1
  reset_codes_chk: assert property (@(posedge clk)
    $rose(rstN) |-> thrCodes == {NUM_CH{CODE_W'(RESET_CODE)}});

  // R4
  update_on_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(thrCodes) |-> ($past(serStrobeN, 3) && !$past(serStrobeN, 4)));

  // R8
  idle_dout_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (serStrobeN && $past(serStrobeN) && $past(serStrobeN, 2) && $past(serStrobeN, 3))
      |-> !serDout);

  // R9
  single_chan_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> $onehot0(chanMoved));
endmodule

bind thresh_bank thresh_bank_chk #(.NUM_CH(NUM_CH), .CODE_W(CODE_W),
                                   .RESET_CODE(RESET_CODE)) u_chk (
  .clk(clk), .rstN(rstN), .serStrobeN(serStrobeN), .serDout(serDout),
  .thrCodes(thrCodes));

// File: tb/thresh_bank_bench.sv
module thresh_bank_bench;
  localparam int NUM_CH = 16;
  localparam int CODE_W = 7;
  localparam int HALF   = 8;

  logic clk = 0, rstN = 0, serClk = 0, serDin = 0, serStrobeN = 1;
  logic serDout;
  logic [NUM_CH*CODE_W-1:0] thrCodes;

  int total = 0, bad = 0;
  logic [6:0] model [NUM_CH];
  logic [6:0] expQ [$];
  logic [6:0] capWord;
  string      capTag;
  event       capEv;
  bit         done = 0;

  always #2.5 clk = ~clk;

  thresh_bank u_thresh_bank (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serDin(serDin),
    .serStrobeN(serStrobeN), .serDout(serDout), .thrCodes(thrCodes));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // sends nbits of word (MSB of a 13-bit field first), captures dout before edges 6..12
  task automatic sendFrame(input logic [12:0] word, input int nbits, input bit capture);
    logic [6:0] cap = '0;
    serStrobeN = 0;
    waitClk(HALF);
    for (int k = 1; k <= nbits; k++) begin
      serDin = word[13-k];
      serClk = 0;
      waitClk(HALF);
      if (capture && k >= 6 && k <= 12) cap[12-k] = serDout;
      serClk = 1;
      waitClk(HALF);
    end
    serClk = 0;
    waitClk(HALF);
    serStrobeN = 1;
    waitClk(HALF);
    if (capture) begin
      capWord = cap;
      ->capEv;
      #1;
    end
  endtask

  task automatic writeCh(input int ch, input logic [6:0] code);
    sendFrame({1'b1, 4'(ch), code, 1'b0}, 12, 0);
    model[ch] = code;
  endtask

  task automatic readCh(input int ch, input logic [6:0] junk, input string tag);
    expQ.push_back(model[ch]);
    capTag = tag;
    sendFrame({1'b0, 4'(ch), junk, 1'b0}, 12, 1);
  endtask

  task automatic checkAll(input string req);
    for (int c = 0; c < NUM_CH; c++)
      check(thrCodes[c*CODE_W +: CODE_W] == model[c], req,
            thrCodes[c*CODE_W +: CODE_W], model[c]);
  endtask

  // monitor: pops the expected readback and compares
  initial begin
    forever begin
      @(capEv);
      if (expQ.size() == 0) check(0, "R6 unexpected readback", capWord, 0);
      else begin
        automatic logic [6:0] e = expQ.pop_front();
        check(capWord == e, capTag, capWord, e);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      check(0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NUM_CH; c++) model[c] = 7'd64;
    waitClk(5);
    rstN = 1;
    waitClk(5);
    // R1 reset state
    checkAll("R1 reset code");
    check(serDout == 0, "R1 dout low", serDout, 0);

    // R2 R3 writes, including boundary channels and codes
    writeCh(3, 7'h15);
    checkAll("R2 write ch3");
    writeCh(15, 7'h7F);
    writeCh(0, 7'h00);
    writeCh(8, 7'h2A);
    checkAll("R3 field order ch0/8/15");

    // R6 readback
    readCh(3, 7'h00, "R6 read ch3");
    readCh(15, 7'h00, "R6 read ch15");
    readCh(0, 7'h00, "R6 read ch0");
    readCh(7, 7'h00, "R6 read ch7 default");
    readCh(8, 7'h00, "R6 read ch8");

    // R7 read with all-ones data changes nothing
    readCh(1, 7'h7F, "R7 read ch1");
    checkAll("R7 read no write");

    // R4 short frame
    sendFrame({1'b1, 4'd5, 7'h11, 1'b0}, 11, 0);
    checkAll("R4 short frame");
    // R5 long frame
    sendFrame({1'b1, 4'd5, 7'h11, 1'b1}, 13, 0);
    checkAll("R5 long frame");

    // R8 clock toggles with strobe high
    serDin = 1;
    for (int i = 0; i < 6; i++) begin
      serClk = 1; waitClk(HALF);
      serClk = 0; waitClk(HALF);
    end
    check(serDout == 0, "R8 idle dout", serDout, 0);
    writeCh(5, 7'h33);
    checkAll("R8 next frame aligned");

    // R2 overwrite holds new value
    writeCh(3, 7'h4C);
    checkAll("R2 overwrite ch3");
    readCh(3, 7'h00, "R2 readback overwrite");
    readCh(5, 7'h00, "R6 read ch5");
    check(serDout == 0, "R8 dout after read", serDout, 0);

    waitClk(10);
    check(expQ.size() == 0, "R6 all reads returned", expQ.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule